// File: doc/BRIEF.md
# Pipelined Converter Digital Error Correction

This block sits behind the comparator outputs of a seven-stage pipelined analog-to-digital converter and turns them into one 14-bit word for each sample. Each stage reports how many of its comparators tripped. Because the stages work on a sample one after another, the codes for any given sample arrive on different strobes. A skew chain of delay registers holds each stage's code until the last stage has resolved the same sample. A single adder then sums the codes at their weights. The redundant bit in each stage overlaps the next stage's range, so a comparator offset that shifts one stage's decision is cancelled by the residue that the next stage sees.

The stage plan is uneven. The first stage resolves 3 effective bits and uses 14 comparators, so its code runs from 0 to 14. Five middle stages resolve 2 effective bits each with 6 comparators, so their codes run from 0 to 6. A final flash stage of 1 bit has a single comparator and no redundancy. Two extra comparators in the first stage detect an input beyond the converter's range, one for each polarity. These two bits travel down the skew chain with the first-stage code. After alignment they become a range flag and force the output word to a rail.

Top module: `pipe_adc_corrector`

## Requirements
- R1: For an in-range sample, out_word equals first*1024 + m1*256 + m2*64 + m3*16 + m4*4 + m5*1 + last. Here first is the 4-bit first-stage comparator count, m1..m5 are the 3-bit middle-stage counts (m1 in mid_codes[2:0], m(j) in mid_codes[3j-1:3j-3]) and last is the 1-bit flash code.
- R2: If that sum exceeds 16383, out_word is 16383 and out_range stays 0.
- R3: If the aligned over_hi bit is 1, out_word is 16383 and out_range is 1, whatever the stage codes are.
- R4: If the aligned over_lo bit is 1 and over_hi is 0, out_word is 0 and out_range is 1. over_hi wins when both are set.
- R5: The first-stage code and range bits of a sample are taken on strobe s. The code of middle stage j is taken on strobe s+j, and the flash code on strobe s+6. These seven pieces are combined into one word.
- R6: After reset, out_valid stays 0 for the first six strobes. From the seventh strobe on, each strobe raises out_valid in the next cycle and presents the word of the sample whose first-stage code came six strobes earlier.
- R7: In a cycle that follows a cycle with in_valid low, out_valid is 0 and out_word and out_range keep their values. The alignment does not advance on such cycles.
- R8: While rst_n is low, out_valid, out_word and out_range are 0. After reset ends, the six-strobe fill of R6 starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe: stage codes on the inputs are valid this cycle |
| first_code | input | 4 | Comparator count of the 3-bit first stage (0 to 14) |
| mid_codes | input | 15 | Five 3-bit comparator counts of the middle stages, stage 2 in the low bits |
| last_code | input | 1 | Flash stage code |
| over_hi | input | 1 | First-stage detector: input above the range |
| over_lo | input | 1 | First-stage detector: input below the range |
| out_valid | output | 1 | Corrected word valid |
| out_word | output | 14 | Corrected output word |
| out_range | output | 1 | Range flag of the sample on out_word |

## Verification
A fault in the skew chain would mix codes from neighbouring samples. The bench therefore feeds a stream of unlike samples back to back, and a misaligned stage shows up as a wrong word on the first valid output after it. A weighting or carry error moves the two redundant mid-scale samples (7,3,3,3,3,3,0 and 8,0,0,0,0,0,0) apart from the adjacent values 8191 and 8192, and it does so on the first word. Fill-counter faults show as out_valid rising one strobe early or late. Faults in the hold logic show within the two-cycle gap inserted into the stream.

// File: rtl/pipe_adc_corrector.sv
module pipe_adc_corrector #(
  parameter int FIRST_BITS = 3,
  parameter int MID_BITS   = 2,
  parameter int MID_STAGES = 5,
  parameter int LAST_BITS  = 1
) (
  input  logic                                                 clk,
  input  logic                                                 rst_n,
  input  logic                                                 in_valid,
  input  logic [FIRST_BITS:0]                                  first_code,
  input  logic [MID_STAGES*(MID_BITS+1)-1:0]                   mid_codes,
  input  logic [LAST_BITS-1:0]                                 last_code,
  input  logic                                                 over_hi,
  input  logic                                                 over_lo,
  output logic                                                 out_valid,
  output logic [FIRST_BITS+MID_BITS*MID_STAGES+LAST_BITS-1:0]  out_word,
  output logic                                                 out_range
);
  localparam int NSTAGE = MID_STAGES + 2;
  localparam int OUT_W  = FIRST_BITS + MID_BITS*MID_STAGES + LAST_BITS;
  localparam int FCW    = FIRST_BITS + 1;
  localparam int MCW    = MID_BITS + 1;
  localparam int SUM_W  = OUT_W + 1;
  localparam int SH0    = OUT_W - FIRST_BITS - 1;
  localparam int CNT_W  = $clog2(NSTAGE);

  logic [FCW+1:0]   fchain [NSTAGE-1];
  logic [MCW-1:0]   mid_al [MID_STAGES];
  logic [FCW+1:0]   f_al;
  logic [SUM_W-1:0] sum;
  logic [OUT_W-1:0] res;
  logic [CNT_W-1:0] fill;
  logic             full;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      for (int i = 0; i < NSTAGE-1; i++) fchain[i] <= '0;
    else if (in_valid) begin
      fchain[0] <= {over_hi, over_lo, first_code};
      for (int i = 1; i < NSTAGE-1; i++) fchain[i] <= fchain[i-1];
    end

  assign f_al = fchain[NSTAGE-2];

  for (genvar m = 0; m < MID_STAGES; m++) begin : g_mid
    localparam int D = MID_STAGES - m;
    logic [MCW-1:0] mchain [D];
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        for (int i = 0; i < D; i++) mchain[i] <= '0;
      else if (in_valid) begin
        mchain[0] <= mid_codes[m*MCW +: MCW];
        for (int i = 1; i < D; i++) mchain[i] <= mchain[i-1];
      end
    assign mid_al[m] = mchain[D-1];
  end

  always_comb begin
    sum = SUM_W'(f_al[FCW-1:0]) << SH0;
    for (int m = 0; m < MID_STAGES; m++)
      sum = sum + (SUM_W'(mid_al[m]) << (SH0 - MID_BITS*(m+1)));
    sum = sum + SUM_W'(last_code);
  end

  always_comb begin
    if (f_al[FCW+1])      res = '1;
    else if (f_al[FCW])   res = '0;
    else if (sum[OUT_W])  res = '1;
    else                  res = sum[OUT_W-1:0];
  end

  assign full = (fill == CNT_W'(NSTAGE-1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) fill <= '0;
    else if (in_valid && !full) fill <= fill + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_range <= 1'b0;
    end else begin
      out_valid <= in_valid && full;
      if (in_valid && full) begin
        out_word  <= res;
        out_range <= f_al[FCW+1] | f_al[FCW];
      end
    end
endmodule

// File: rtl/pipe_adc_corrector_chk.sv
module pipe_adc_corrector_chk #(
  parameter int NSTAGE = 7,
  parameter int OUT_W  = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_word,
  input logic             out_range
);
  logic [7:0] strobes;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) strobes <= '0;
    else if (in_valid && strobes < 8'(NSTAGE-1)) strobes <= strobes + 1'b1;

  p_reset_clear_r8: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_word == '0 && !out_range));

  p_gap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_word) && $stable(out_range)));

  p_rail_on_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_range |-> (out_word == '1 || out_word == '0));

  p_fill_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && strobes < 8'(NSTAGE-1)) |=> !out_valid);

  p_fill_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && strobes == 8'(NSTAGE-1)) |=> out_valid);
endmodule

bind pipe_adc_corrector pipe_adc_corrector_chk #(.NSTAGE(MID_STAGES+2), .OUT_W(OUT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .out_valid(out_valid), .out_word(out_word), .out_range(out_range)
);

// File: tb/pipe_adc_corrector_tb_top.sv
module pipe_adc_corrector_tb_top;
  localparam int NT = 10;
  localparam int VW = 36;
  // {hi, lo, first[3:0], m1..m5 [2:0] each, last, expected[13:0]}
  localparam logic [VW-1:0] TBL [NT] = '{
    {1'b0,1'b0,4'd0, 3'd0,3'd0,3'd0,3'd0,3'd0,1'd0,14'd0},
    {1'b0,1'b0,4'd14,3'd6,3'd6,3'd6,3'd6,3'd6,1'd1,14'd16383},
    {1'b0,1'b0,4'd7, 3'd3,3'd3,3'd3,3'd3,3'd3,1'd0,14'd8191},
    {1'b0,1'b0,4'd8, 3'd0,3'd0,3'd0,3'd0,3'd0,1'd0,14'd8192},
    {1'b0,1'b0,4'd1, 3'd2,3'd0,3'd5,3'd1,3'd4,1'd1,14'd1625},
    {1'b1,1'b0,4'd3, 3'd3,3'd3,3'd3,3'd3,3'd3,1'd0,14'd16383},
    {1'b0,1'b1,4'd14,3'd0,3'd0,3'd0,3'd0,3'd0,1'd0,14'd0},
    {1'b0,1'b0,4'd15,3'd7,3'd0,3'd0,3'd0,3'd0,1'd0,14'd16383},
    {1'b0,1'b0,4'd0, 3'd1,3'd0,3'd0,3'd0,3'd0,1'd1,14'd257},
    {1'b1,1'b1,4'd2, 3'd0,3'd0,3'd0,3'd0,3'd0,1'd0,14'd16383}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  first_code = '0;
  logic [14:0] mid_codes = '0;
  logic [0:0]  last_code = '0;
  logic        over_hi = 1'b0, over_lo = 1'b0;
  logic        out_valid;
  logic [13:0] out_word;
  logic        out_range;
  int checks = 0, errors = 0;
  logic [13:0] held_word;
  logic        held_range;

  always #5 clk = ~clk;

  pipe_adc_corrector dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .first_code(first_code), .mid_codes(mid_codes), .last_code(last_code),
    .over_hi(over_hi), .over_lo(over_lo),
    .out_valid(out_valid), .out_word(out_word), .out_range(out_range)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic string req_of(input int s);
    if (s == 5) return "R3";
    if (s == 6 || s == 9) return "R4";
    if (s == 7) return "R2";
    return "R1 R5";
  endfunction

  task automatic drive(input int t);
    first_code = '0; mid_codes = '0; last_code = '0; over_hi = 1'b0; over_lo = 1'b0;
    if (t >= 0 && t < NT) begin
      first_code = TBL[t][33:30];
      over_hi    = TBL[t][35];
      over_lo    = TBL[t][34];
    end
    for (int m = 0; m < 5; m++)
      if (t-m-1 >= 0 && t-m-1 < NT)
        mid_codes[3*m +: 3] = TBL[t-m-1][27-3*m +: 3];
    if (t-6 >= 0 && t-6 < NT) last_code = TBL[t-6][14];
    in_valid = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset valid", 32'(out_valid), 0);
    chk("R8 reset word", 32'(out_word), 0);
    chk("R8 reset range", 32'(out_range), 0);
    rst_n = 1'b1;
    for (int t = 0; t < NT + 6; t++) begin
      drive(t);
      @(negedge clk);
      if (t < 6) chk("R6 fill quiet", 32'(out_valid), 0);
      else begin
        chk("R6 valid", 32'(out_valid), 1);
        chk(req_of(t-6), 32'(out_word), 32'(TBL[t-6][13:0]));
        chk({req_of(t-6), " flag"}, 32'(out_range), 32'(TBL[t-6][35] | TBL[t-6][34]));
      end
      if (t == 8) begin
        held_word = out_word; held_range = out_range;
        in_valid = 1'b0; first_code = 4'd9; mid_codes = '1; over_hi = 1'b1;
        for (int g = 0; g < 2; g++) begin
          @(negedge clk);
          chk("R7 gap valid", 32'(out_valid), 0);
          chk("R7 gap word", 32'(out_word), 32'(held_word));
          chk("R7 gap range", 32'(out_range), 32'(held_range));
        end
      end
    end
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R8 mid reset valid", 32'(out_valid), 0);
    chk("R8 mid reset word", 32'(out_word), 0);
    chk("R8 mid reset range", 32'(out_range), 0);
    rst_n = 1'b1;
    drive(1);
    @(negedge clk);
    chk("R8 fill restarts", 32'(out_valid), 0);
    in_valid = 1'b0;
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule